// File: doc/BRIEF.md
# Restartable 32-bit Interval Timer with Capture

This block is a 32-bit up-counter paced by the system clock. Software programs it through a single-cycle register port with no wait states: a control word, a period, a shadow reload value, the live count and a capture register. When a cycle completes, the counter wraps to zero and raises a one-clock pulse on three outputs: interrupt, event and output pin. The block can run one cycle and stop, run without end, or run without end and take a fresh period from the reload register at each cycle boundary.

Two extra ways of restarting a cycle sit behind a global enhanced-features bit. In the first, a chosen edge on an external input restarts the cycle. In the second, a read of the count register restarts it. Either restart copies the running count into the capture register, reloads the period in reload mode and starts again from zero. Only the edge-driven restart produces output pulses. The external input passes through a two-stage synchronizer before its edges are detected.

Top module: `capture_timer32`

## Requirements
- R1: After reset every register reads 0 and all three outputs are low. The register addresses are 0 control, 1 period, 2 reload, 3 count and 4 capture. The control word fields are: bit 0 run (release from hold), bits 2:1 mode (0 off, 1 one-shot, 2 continuous, 3 continuous with reload), bit 3 external-clock select, bit 4 capture enable, bits 6:5 edge select, bit 7 read-restart enable and bit 8 enhanced enable.
- R2: While the run bit is 0, the count stays 0 and no pulse appears, whatever the mode.
- R3: With the counter running, a cycle lasts period+1 clocks. At each wrap, the interrupt, event and pin outputs pulse high together for one clock.
- R4: In mode 3 the reload register is copied into the period register at every wrap. A reload value written partway through a cycle sets the length of the next cycle.
- R5: In mode 1 the timer completes one cycle, pulses once, and then clears the mode field to 0. The count then stays at 0.
- R6: A capture restart can happen only when all of the following hold: enhanced enable is 1, the clock select is 0, the mode is 2 or 3, and capture enable is 1.
- R7: The edge-select values are 0 for rising, 1 for falling, and 2 or 3 for either edge. An edge that is not selected has no effect.
- R8: On a qualifying edge, the count is latched into the capture register and the counter restarts from 0. The output pulse appears on the third clock edge after the input changes, and the captured value is the count seen just before the input changed plus 2.
- R9: A capture restart in mode 3 loads the period from the reload register. This hardware load takes priority over a software write to the period in the same clock.
- R10: When enhanced enable and read-restart enable are both set and the mode is 2 or 3, a read of the count register returns the current count, copies it into the capture register, reloads the period in mode 3 and restarts the count from 0. No output pulse is produced.
- R11: When read-restart is disabled, reading the count has no side effect, and consecutive reads return values that rise by 1.
- R12: If a capture edge and a count read fall in the same clock, only one restart takes place. It is handled as a capture restart, so it pulses. The read returns the count as it was before the restart, and that value is also the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives the read restart) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ext_evt_i | input | 1 | Asynchronous external event input |
| irq_o | output | 1 | Interrupt pulse |
| evt_o | output | 1 | Event pulse |
| pin_o | output | 1 | Output pin pulse |

## Verification
The capture restart and the read restart can both be triggered in the same clock. To provoke this, the bench changes the external input, waits exactly two clocks so that the synchronized edge is being presented, and then issues a read of the count in that clock. The result is judged correct when the read data equals the value later found in the capture register, a pulse appears on the following clock, and the count restarts from zero only once.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

  localparam int CTRL_W = 9;

  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_PERIOD  = 3'd1;
  localparam logic [2:0] ADDR_RELOAD  = 3'd2;
  localparam logic [2:0] ADDR_COUNT   = 3'd3;
  localparam logic [2:0] ADDR_CAPTURE = 3'd4;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ONCE   = 2'd1,
    MODE_CONT   = 2'd2,
    MODE_RELOAD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2,
    EDGE_ANYB = 2'd3
  } edge_e;

  // bit 8 .. bit 0
  typedef struct packed {
    logic  enh;
    logic  rdrst_en;
    edge_e edge_sel;
    logic  cap_en;
    logic  clk_ext;
    mode_e mode;
    logic  run;
  } ctrl_t;

  function automatic logic edge_hit(edge_e sel, logic cur, logic prev);
    case (sel)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      default:   return cur ^ prev;
    endcase
  endfunction

  function automatic logic capture_allowed(ctrl_t c);
    return c.run & c.enh & ~c.clk_ext & c.mode[1] & c.cap_en;
  endfunction

  function automatic logic read_restart_allowed(ctrl_t c);
    return c.run & c.enh & ~c.clk_ext & c.mode[1] & c.rdrst_en;
  endfunction

  function automatic logic counting(ctrl_t c);
    return c.run & (c.mode != MODE_OFF) & ~c.clk_ext;
  endfunction

endpackage

// File: rtl/ctimer_edge.sv
module ctimer_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic cur_o,
  output logic prev_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[s] <= 1'b0;
          else         sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign cur_o  = sync_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/ctimer_core.sv
module ctimer_core
  import ctimer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ctrl_t        ctrl_i,
  input  logic [W-1:0] period_i,
  input  logic         rd_cnt_i,
  input  logic         sync_cur_i,
  input  logic         sync_prev_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] capture_o,
  output logic         pulse_o,
  output logic         cap_evt_o,
  output logic         rd_restart_o,
  output logic         wrap_o,
  output logic         load_period_o,
  output logic         oneshot_done_o
);
  logic [W-1:0] count_q, capture_q;
  logic         pulse_q;
  logic         active, restart;

  assign active       = counting(ctrl_i);
  assign cap_evt_o    = capture_allowed(ctrl_i) &
                        edge_hit(ctrl_i.edge_sel, sync_cur_i, sync_prev_i);
  assign rd_restart_o = read_restart_allowed(ctrl_i) & rd_cnt_i & ~cap_evt_o;
  assign wrap_o       = active & (count_q == period_i) & ~cap_evt_o & ~rd_restart_o;
  assign restart      = cap_evt_o | rd_restart_o;

  assign load_period_o  = (restart | wrap_o) & (ctrl_i.mode == MODE_RELOAD);
  assign oneshot_done_o = wrap_o & (ctrl_i.mode == MODE_ONCE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      capture_q <= '0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= cap_evt_o | wrap_o;
      if (restart) capture_q <= count_q;
      if (!ctrl_i.run || restart || wrap_o) count_q <= '0;
      else if (active)                      count_q <= count_q + 1'b1;
    end
  end

  assign count_o   = count_q;
  assign capture_o = capture_q;
  assign pulse_o   = pulse_q;
endmodule

// File: rtl/capture_timer32.sv
module capture_timer32
  import ctimer_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [2:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             ext_evt_i,
  output logic             irq_o,
  output logic             evt_o,
  output logic             pin_o
);
  localparam int PAD_W = WIDTH - CTRL_W;

  ctrl_t            ctrl_q;
  logic [WIDTH-1:0] period_q, reload_q, count, capture;
  logic             sync_cur, sync_prev, pulse;
  logic             cap_evt, rd_restart, wrap, load_period, oneshot_done;
  logic             rd_cnt;
  logic [1:0]       mode;

  assign rd_cnt = rd_en_i & (addr_i == ADDR_COUNT);
  assign mode   = ctrl_q.mode;

  ctimer_edge #(.STAGES(SYNC_DEPTH)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_evt_i),
    .cur_o  (sync_cur),
    .prev_o (sync_prev)
  );

  ctimer_core #(.W(WIDTH)) u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_i        (ctrl_q),
    .period_i      (period_q),
    .rd_cnt_i      (rd_cnt),
    .sync_cur_i    (sync_cur),
    .sync_prev_i   (sync_prev),
    .count_o       (count),
    .capture_o     (capture),
    .pulse_o       (pulse),
    .cap_evt_o     (cap_evt),
    .rd_restart_o  (rd_restart),
    .wrap_o        (wrap),
    .load_period_o (load_period),
    .oneshot_done_o(oneshot_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '0;
      reload_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      else if (oneshot_done)              ctrl_q.mode <= MODE_OFF;
      if (load_period)                          period_q <= reload_q;
      else if (wr_en_i && addr_i == ADDR_PERIOD) period_q <= wdata_i;
      if (wr_en_i && addr_i == ADDR_RELOAD) reload_q <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL:    rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      ADDR_PERIOD:  rdata_o = period_q;
      ADDR_RELOAD:  rdata_o = reload_q;
      ADDR_COUNT:   rdata_o = count;
      ADDR_CAPTURE: rdata_o = capture;
      default:      rdata_o = '0;
    endcase
  end

  assign irq_o = pulse;
  assign evt_o = pulse;
  assign pin_o = pulse;
endmodule

// File: rtl/capture_timer32_chk.sv
module capture_timer32_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic [1:0]   mode_i,
  input logic         cap_evt_i,
  input logic         rd_restart_i,
  input logic         wrap_i,
  input logic [W-1:0] count_i,
  input logic [W-1:0] capture_i,
  input logic [W-1:0] period_i,
  input logic [W-1:0] reload_i,
  input logic         irq_i,
  input logic         evt_i,
  input logic         pin_i
);
  p_outs_equal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == evt_i) && (irq_i == pin_i));

  p_wrap_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> irq_i);

  p_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (count_i == '0));

  p_restart_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> (count_i == '0) && irq_i);

  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> (capture_i == $past(count_i)));

  p_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && mode_i == 2'd3) |=> (period_i == $past(reload_i)));

  p_read_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_restart_i && !cap_evt_i) |=> !irq_i && (count_i == '0));

  p_single_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_evt_i && rd_restart_i));
endmodule

bind capture_timer32 capture_timer32_chk #(.W(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (ctrl_q.run),
  .mode_i      (mode),
  .cap_evt_i   (cap_evt),
  .rd_restart_i(rd_restart),
  .wrap_i      (wrap),
  .count_i     (count),
  .capture_i   (capture),
  .period_i    (period_q),
  .reload_i    (reload_q),
  .irq_i       (irq_o),
  .evt_i       (evt_o),
  .pin_i       (pin_o)
);

// File: tb/test_capture_timer32.sv
module test_capture_timer32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext = 1'b0;
  logic        irq, evt, pin;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  capture_timer32 i_capture_timer32 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ext_evt_i(ext),
    .irq_o(irq), .evt_o(evt), .pin_o(pin)
  );

  // vector table: mode, period, reload
  localparam int NV = 4;
  localparam int V_MODE [NV] = '{2, 2, 3, 2};
  localparam int V_PER  [NV] = '{4, 0, 6, 17};
  localparam int V_REL  [NV] = '{0, 0, 2, 0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int run, int mode, int ce, int cap, int edg, int rr, int enh);
    return 32'(run) | (32'(mode) << 1) | (32'(ce) << 3) | (32'(cap) << 4) |
           (32'(edg) << 5) | (32'(rr) << 7) | (32'(enh) << 8);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_pulse(input int lim, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < lim);
  endtask

  task automatic probe(input logic val, input logic hit, input string req);
    logic [31:0] c0, cap0, v;
    @(negedge clk);
    peek(3'd3, c0); peek(3'd4, cap0); ext = val;
    @(negedge clk); chk(req, 32'(irq), 0);
    @(negedge clk); chk(req, 32'(irq), 0);
    @(negedge clk); chk(req, 32'(irq), 32'(hit));
    if (hit) begin
      peek(3'd4, v); chk(req, v, c0 + 2);
      peek(3'd3, v); chk(req, v, 0);
    end else begin
      peek(3'd4, v); chk(req, v, cap0);
    end
    @(negedge clk); chk(req, 32'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, c, a, b;
    int n, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      peek(3'(r), v); chk("R1 reg", v, 0);
    end
    chk("R1 out", {29'd0, irq, evt, pin}, 0);

    // R2 held without run bit
    wr(3'd1, 32'd3);
    wr(3'd0, mk(0, 2, 0, 0, 0, 0, 0));
    seen = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (irq) seen++; end
    peek(3'd3, v); chk("R2 count", v, 0);
    chk("R2 pulses", 32'(seen), 0);

    // R3/R4 vector table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 32'd0);
      wr(3'd1, 32'(V_PER[i]));
      wr(3'd2, 32'(V_REL[i]));
      wr(3'd0, mk(1, V_MODE[i], 0, 0, 0, 0, 0));
      wait_pulse(100, n);
      chk("R3 all outputs", {29'd0, irq, evt, pin}, 7);
      wait_pulse(100, n);
      chk(V_MODE[i] == 3 ? "R4 gap" : "R3 gap", 32'(n),
          32'(V_MODE[i] == 3 ? V_REL[i] + 1 : V_PER[i] + 1));
    end

    // R4 reload written mid-cycle
    wr(3'd0, 32'd0); wr(3'd1, 32'd9); wr(3'd2, 32'd9);
    wr(3'd0, mk(1, 3, 0, 0, 0, 0, 0));
    wait_pulse(100, n);
    addr = 3'd2; wdata = 32'd4; wr_en = 1'b1;
    n = 0;
    do begin @(negedge clk); wr_en = 1'b0; n++; end while (!irq && n < 100);
    chk("R4 current gap", 32'(n), 10);
    wait_pulse(100, n);
    chk("R4 next gap", 32'(n), 5);

    // R5 one-shot
    wr(3'd0, 32'd0); wr(3'd1, 32'd3);
    wr(3'd0, mk(1, 1, 0, 0, 0, 0, 0));
    wait_pulse(50, n);
    chk("R5 pulse", 32'(irq), 1);
    seen = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (irq) seen++; end
    chk("R5 no more", 32'(seen), 0);
    peek(3'd3, v); chk("R5 count", v, 0);
    peek(3'd0, v); chk("R5 mode", (v >> 1) & 32'd3, 0);

    // R6..R9 capture
    wr(3'd0, 32'd0); wr(3'd1, 32'd5000); wr(3'd2, 32'd4000);
    wr(3'd0, mk(1, 3, 0, 1, 0, 0, 1));
    repeat (5) @(negedge clk);
    probe(1'b1, 1'b1, "R8 rise");
    peek(3'd1, v); chk("R9 period", v, 4000);
    probe(1'b0, 1'b0, "R7 fall ignored");
    wr(3'd0, mk(1, 3, 0, 1, 1, 0, 1));
    probe(1'b1, 1'b0, "R7 rise ignored");
    probe(1'b0, 1'b1, "R7 fall");
    wr(3'd0, mk(1, 2, 0, 1, 2, 0, 1));
    probe(1'b1, 1'b1, "R7 any rise");
    probe(1'b0, 1'b1, "R7 any fall");
    wr(3'd0, mk(1, 2, 0, 1, 2, 0, 0));
    probe(1'b1, 1'b0, "R6 enh off");
    wr(3'd0, mk(1, 2, 0, 0, 2, 0, 1));
    probe(1'b0, 1'b0, "R6 cap off");
    wr(3'd0, mk(1, 2, 1, 1, 2, 0, 1));
    probe(1'b1, 1'b0, "R6 ext clock");
    wr(3'd0, mk(1, 1, 0, 1, 2, 0, 1));
    probe(1'b0, 1'b0, "R6 one-shot");

    // R11 read without restart
    wr(3'd0, mk(1, 2, 0, 1, 0, 0, 1));
    @(negedge clk); addr = 3'd3; rd_en = 1'b1; #1 a = rdata;
    @(negedge clk); #1 b = rdata; rd_en = 1'b0;
    chk("R11 reads", b, a + 1);

    // R10 read restart
    wr(3'd2, 32'd77);
    wr(3'd0, mk(1, 3, 0, 0, 0, 1, 1));
    repeat (6) @(negedge clk);
    @(negedge clk); addr = 3'd3; rd_en = 1'b1; #1 c = rdata;
    @(negedge clk); rd_en = 1'b0;
    chk("R10 no pulse", 32'(irq), 0);
    peek(3'd4, v); chk("R10 capture", v, c);
    peek(3'd3, v); chk("R10 count", v, 0);
    peek(3'd1, v); chk("R10 reload", v, 77);
    seen = 0;
    for (int k = 0; k < 3; k++) begin @(negedge clk); if (irq) seen++; end
    chk("R10 quiet", 32'(seen), 0);

    // R12 collision
    wr(3'd1, 32'd5000); wr(3'd2, 32'd5000);
    wr(3'd0, mk(1, 2, 0, 1, 0, 1, 1));
    repeat (3) @(negedge clk);
    @(negedge clk); ext = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 3'd3; rd_en = 1'b1; #1 c = rdata;
    @(negedge clk); rd_en = 1'b0;
    chk("R12 pulse", 32'(irq), 1);
    peek(3'd4, v); chk("R12 capture", v, c);
    peek(3'd3, v); chk("R12 count", v, 0);
    @(negedge clk); chk("R12 single", 32'(irq), 0);
    peek(3'd3, v); chk("R12 counting", v, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule